// File: doc/BRIEF.md
# Streamed-Duty PWM Channel

This block is a single PWM output whose duty value changes from one period to the next, fed from a small on-block table of compare words. The input clock is divided by a prescaler into count ticks. An up-counter runs from zero to a programmable reload value and then wraps, so each period lasts reload+1 ticks. The compare value sits in two registers. A staging register takes new words at any time. A working register copies the staging register only when the counter wraps. A word that arrives in mid-period therefore shapes the next period, not the current one.

A refill engine moves table words into the staging register. A trigger raises a single pending flag. After a programmable number of ticks the engine acknowledges it, writes the word under its pointer into the staging register and steps the pointer, which returns to entry 0 after a programmable last index. The trigger can be the wrap (update) event or the compare event. With the update event there is exactly one refill per period, so every table word drives exactly one period. With the compare event, a compare that fires after a refill in the same period starts a second refill before the next wrap. The earlier word is then overwritten unused, and the output shows one pulse fewer than the table holds. The block exposes this behaviour on purpose, so that both settings can be compared.

Top module: `pwm_stream_top`

## Requirements
- R1: While `en_i` is 1, a count tick occurs once every `psc_i`+1 clocks. While `en_i` is 0, the prescaler, counter and all events hold, and `upd_o`, `cmp_o` stay 0.
- R2: On each tick the counter steps by one. On the tick where it equals `arr_i` it returns to 0 and `upd_o` pulses for that clock, so a period is `arr_i`+1 ticks.
- R3: The working compare value loads the staging value only on an update event. A staging write in mid-period affects only the following period.
- R4: With working compare value C ≤ `arr_i`, `cmp_o` pulses on the tick where the counter equals C. With C > `arr_i`, `cmp_o` pulses together with `upd_o`.
- R5: The output is active while counter < C. So C = 0 gives no active cycle, and C > `arr_i` gives a fully active period. `pol_i`=0 makes active = 1, and `pol_i`=1 makes active = 0.
- R6: `src_sel_i`=0 selects the update event as refill trigger, and `src_sel_i`=1 selects the compare event. `req_o` shows the pending flag, which is set on the clock after a trigger tick.
- R7: A pending request is serviced on the `lat_i`-th tick after its trigger tick (0 acts as 1). Servicing writes table[pointer] into the staging register and advances the pointer, which wraps from `tbl_last_i` to 0. `tbl_we_i` writes `tbl_wdata_i` at `tbl_addr_i`.
- R8: A trigger that arrives while a request is pending is dropped, not queued. The pending flag clears only when the request is serviced.
- R9: With the update trigger and a latency shorter than a period, exactly one refill lands in each period after the first, and table words appear as consecutive period widths in table order.
- R10: With the compare trigger, an in-range compare after a refill in the same period causes two refills in the following period, and one table word never reaches the output.
- R11: After reset, the prescaler, counter, working and staging compare values and table pointer are 0, nothing is pending, and `pwm_o` equals `pol_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Count enable |
| psc_i | input | CNT_W | Prescaler setting (divide by value+1) |
| arr_i | input | CNT_W | Reload value (last count of a period) |
| src_sel_i | input | 1 | Refill trigger: 0 update, 1 compare |
| pol_i | input | 1 | Output polarity: 1 makes the active level low |
| lat_i | input | LAT_W | Refill service latency in ticks |
| tbl_last_i | input | $clog2(DEPTH) | Index of the last table entry before wrap |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_addr_i | input | $clog2(DEPTH) | Table write index |
| tbl_wdata_i | input | CNT_W | Table write word |
| pwm_o | output | 1 | PWM pin |
| upd_o | output | 1 | Update (wrap) event strobe |
| cmp_o | output | 1 | Compare event strobe |
| req_o | output | 1 | Refill request pending |

## Verification
On every cycle the assertions check the counter stepping and wrap, the rule that the working and staging compare registers and the table pointer change only on update and acknowledge, the pending flag holding until it is serviced, and the output being inactive on an in-range compare tick. Only the bench scenarios can show the period-level results. These are the width sequence produced by each trigger source, the lost table word and doubled refill under compare triggering, the halved refill rate when latency exceeds a period, prescaler scaling, and polarity inversion.

// File: rtl/pwm_stream_pkg.sv
package pwm_stream_pkg;
  typedef enum logic {
    SRC_UPDATE  = 1'b0,
    SRC_COMPARE = 1'b1
  } refill_src_e;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] psc_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o,
  output logic             upd_o
);
  logic [CNT_W-1:0] pre_q, pre_d, cnt_q, cnt_d;

  always_comb begin
    tick_o = en_i && (pre_q >= psc_i);
    upd_o  = tick_o && (cnt_q >= arr_i);
    pre_d  = pre_q;
    cnt_d  = cnt_q;
    if (en_i) pre_d = tick_o ? '0 : pre_q + CNT_W'(1);
    if (tick_o) cnt_d = upd_o ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R2: a wrap always leaves the counter at zero
  assert_wrap_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> (cnt_q == '0)) else $error("counter not zero after update");
  // R2: a non-wrapping tick advances by exactly one
  assert_step_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !upd_o) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))) else $error("bad step");
  // R1: no tick, no counter movement
  assert_hold_no_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(cnt_q)) else $error("counter moved without tick");
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             upd_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic             pol_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_data_i,
  output logic             cmp_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] stage_q, stage_d, work_q, work_d;
  logic             active;

  always_comb begin
    stage_d = ld_i  ? ld_data_i : stage_q;
    work_d  = upd_i ? stage_q   : work_q;
    active  = cnt_i < work_q;
    cmp_o   = tick_i && ((work_q > arr_i) ? upd_i : (cnt_i == work_q));
    pwm_o   = active ^ pol_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      work_q  <= '0;
    end else begin
      stage_q <= stage_d;
      work_q  <= work_d;
    end
  end

  // R3: working compare value moves only on an update
  assert_work_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(work_q)) else $error("working compare changed mid-period");
  // R7: staging value moves only on a refill acknowledge
  assert_stage_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(stage_q)) else $error("staging changed without refill");
  // R4/R5: on an in-range compare tick the output is already inactive
  assert_cmp_inactive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_o && (work_q <= arr_i)) |-> (pwm_o == pol_i)) else $error("active at compare");
endmodule

// File: rtl/pwm_refill.sv
module pwm_refill #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int LAT_W  = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW1   = LAT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              trig_i,
  input  logic [LAT_W-1:0]  lat_i,
  input  logic [AW-1:0]     last_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              req_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              pend_q, pend_d;
  logic [LAT_W-1:0]  wait_q, wait_d;
  logic [AW-1:0]     ptr_q, ptr_d;
  logic              due;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_comb begin
    due    = (LW1'(wait_q) + LW1'(1)) >= LW1'(lat_i);
    ack_o  = tick_i && pend_q && due;
    pend_d = pend_q;
    wait_d = wait_q;
    ptr_d  = ptr_q;
    if (tick_i) begin
      if (pend_q) begin
        if (due) pend_d = 1'b0;
        else     wait_d = wait_q + LAT_W'(1);
      end else if (trig_i) begin
        pend_d = 1'b1;
        wait_d = '0;
      end
    end
    if (ack_o) ptr_d = (ptr_q == last_i || ptr_q == AW'(DEPTH-1)) ? '0 : ptr_q + AW'(1);
    data_o = mem_q[ptr_q];
    req_o  = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      wait_q <= '0;
      ptr_q  <= '0;
    end else begin
      pend_q <= pend_d;
      wait_q <= wait_d;
      ptr_q  <= ptr_d;
    end
  end

  // R8: a pending request survives until serviced
  assert_pend_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !ack_o) |=> pend_q) else $error("pending dropped early");
  // R8: service clears the flag, a coincident trigger is not queued
  assert_no_queue_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !pend_q) else $error("request queued behind service");
  // R7: pointer moves only on service
  assert_ptr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |=> $stable(ptr_q)) else $error("pointer moved without service");
endmodule

// File: rtl/pwm_stream_top.sv
module pwm_stream_top #(
  parameter int CNT_W = 16,
  parameter int DEPTH = 8,
  parameter int LAT_W = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] psc_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic             src_sel_i,
  input  logic             pol_i,
  input  logic [LAT_W-1:0] lat_i,
  input  logic [AW-1:0]    tbl_last_i,
  input  logic             tbl_we_i,
  input  logic [AW-1:0]    tbl_addr_i,
  input  logic [CNT_W-1:0] tbl_wdata_i,
  output logic             pwm_o,
  output logic             upd_o,
  output logic             cmp_o,
  output logic             req_o
);
  import pwm_stream_pkg::*;

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic [CNT_W-1:0] cnt;
  logic             tick, upd, cmp, trig, ack;
  logic [CNT_W-1:0] fill_data;
  refill_src_e      src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign src  = refill_src_e'(src_sel_i);
  assign trig = (src == SRC_COMPARE) ? cmp : upd;

  pwm_timebase #(.CNT_W(CNT_W)) i_timebase (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(en_i), .psc_i(psc_i), .arr_i(arr_i),
    .cnt_o(cnt), .tick_o(tick), .upd_o(upd)
  );

  pwm_compare #(.CNT_W(CNT_W)) i_compare (
    .clk_i(clk_i), .rst_ni(rst_n), .tick_i(tick), .upd_i(upd), .cnt_i(cnt),
    .arr_i(arr_i), .pol_i(pol_i), .ld_i(ack), .ld_data_i(fill_data),
    .cmp_o(cmp), .pwm_o(pwm_o)
  );

  pwm_refill #(.DATA_W(CNT_W), .DEPTH(DEPTH), .LAT_W(LAT_W)) i_refill (
    .clk_i(clk_i), .rst_ni(rst_n), .tick_i(tick), .trig_i(trig), .lat_i(lat_i),
    .last_i(tbl_last_i), .we_i(tbl_we_i), .waddr_i(tbl_addr_i), .wdata_i(tbl_wdata_i),
    .req_o(req_o), .ack_o(ack), .data_o(fill_data)
  );

  assign upd_o = upd;
  assign cmp_o = cmp;

  // R1: events only exist on ticks
  assert_event_on_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (upd || cmp) |-> tick) else $error("event without tick");
endmodule

// File: tb/test_pwm_stream_top.sv
`timescale 1ns/1ps
module test_pwm_stream_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        en_i, src_sel_i, pol_i, tbl_we_i;
  logic [15:0] psc_i, arr_i, tbl_wdata_i;
  logic [3:0]  lat_i;
  logic [2:0]  tbl_last_i, tbl_addr_i;
  logic        pwm_o, upd_o, cmp_o, req_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int wid [10], plen [10], rfc [10], rhi [10], cpos [10], cupd [10];

  // table: 3, 5, 12 (above reload 9), 7, 2
  localparam int TBL [5] = '{3, 5, 12, 7, 2};
  // rows: psc, arr, src, pol, lat
  localparam int CFG [4][5] = '{
    '{0, 9, 0, 0, 3},
    '{0, 9, 1, 0, 3},
    '{0, 9, 0, 0, 15},
    '{0, 9, 0, 1, 3}};
  localparam int EXP_W [4][10] = '{
    '{0, 0, 3, 5, 10, 7, 2, 3, 5, 10},
    '{0, 3, 5, 10, 10, 7, 2, 5, 10, 10},
    '{0, 0, 0, 3, 3, 5, 5, 10, 10, 7},
    '{0, 0, 3, 5, 10, 7, 2, 3, 5, 10}};

  pwm_stream_top i_pwm_stream_top (
    .clk_i, .rst_ni, .en_i, .psc_i, .arr_i, .src_sel_i, .pol_i, .lat_i,
    .tbl_last_i, .tbl_we_i, .tbl_addr_i, .tbl_wdata_i,
    .pwm_o, .upd_o, .cmp_o, .req_o);

  always #2.5 clk_i = ~clk_i;

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(int pol);
    en_i = 0; tbl_we_i = 0; pol_i = pol[0]; rst_ni = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    repeat (4) @(negedge clk_i);
    for (int i = 0; i < 5; i++) begin
      tbl_we_i = 1; tbl_addr_i = 3'(i); tbl_wdata_i = 16'(TBL[i]);
      @(negedge clk_i);
    end
    tbl_we_i = 0;
  endtask

  task automatic run(int psc, int arr, int src, int pol, int lat, int nper);
    int w = 0, pos = 0, p = 0, rf = 0, rh = 0;
    bit rprev = 0;
    do_reset(pol);
    psc_i = 16'(psc); arr_i = 16'(arr); src_sel_i = src[0];
    lat_i = 4'(lat); tbl_last_i = 3'd4;
    for (int i = 0; i < 10; i++) begin cpos[i] = -1; cupd[i] = 0; end
    en_i = 1;
    #1;
    while (p < nper) begin
      if (pwm_o != pol[0]) w++;
      if (req_o) rh++;
      if (rprev && !req_o) rf++;
      if (cmp_o) begin cpos[p] = pos; cupd[p] = upd_o; end
      rprev = req_o;
      if (upd_o) begin
        wid[p] = w; plen[p] = pos + 1; rfc[p] = rf; rhi[p] = rh;
        w = 0; pos = 0; rf = 0; rh = 0; p++;
      end else pos++;
      @(negedge clk_i);
      #1;
    end
    en_i = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ev;
    psc_i = 0; arr_i = 9; src_sel_i = 0; lat_i = 3; tbl_last_i = 4;
    tbl_addr_i = 0; tbl_wdata_i = 0;
    // R11: reset state, both polarities
    do_reset(0);
    #1;
    chk("R11", pwm_o, 0, "pwm after reset pol0");
    chk("R11", req_o, 0, "req after reset");
    chk("R11", upd_o | cmp_o, 0, "events after reset");
    pol_i = 1; #1;
    chk("R11", pwm_o, 1, "pwm after reset pol1");
    pol_i = 0;
    // R1: disabled holds everything
    ev = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i); #1;
      if (upd_o || cmp_o || req_o) ev++;
    end
    chk("R1", ev, 0, "events while disabled");

    // vector table walk: R3 R5 R9 R10 R8 R11 (pointer restart each reset)
    for (int r = 0; r < 4; r++) begin
      run(CFG[r][0], CFG[r][1], CFG[r][2], CFG[r][3], CFG[r][4], 10);
      for (int k = 0; k < 10; k++)
        chk(r == 1 ? "R10" : (r == 2 ? "R8" : (r == 3 ? "R5" : "R3")),
            wid[k], EXP_W[r][k], $sformatf("row %0d width period %0d", r, k));
      if (r == 0) begin
        for (int k = 1; k < 10; k++) chk("R9", rfc[k], 1, $sformatf("refills period %0d", k));
        chk("R7", rhi[3], 3, "request pending cycles at latency 3");
        chk("R2", plen[4], 10, "period length ticks");
        chk("R6", rhi[0], 0, "no request before first update");
      end
      if (r == 1) begin
        chk("R10", rfc[6], 2, "double refill period");
        chk("R4", cpos[1], 3, "in-range compare position");
        chk("R4", cpos[3], 9, "out-of-range compare at wrap");
        chk("R4", cupd[3], 1, "out-of-range compare with update");
        chk("R6", rfc[3], 0, "no refill in full-active period");
      end
      if (r == 2) chk("R8", rfc[4], 1, "one refill per two periods");
    end

    // R1: prescaler scaling
    run(2, 9, 0, 0, 3, 4);
    chk("R1", plen[1], 30, "period clocks with prescaler 2");
    chk("R1", wid[2], 9, "width clocks with prescaler 2");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule